// File: doc/BRIEF.md
# Function-Call Cycle Profiler

The profiler sits beside an instruction fetch stage and times calls into a small set of chosen functions. Software loads a table of function entry addresses and an end index that says how many table slots, counted from slot 1, are live. Each accepted instruction strobe presents a program counter, the link register value of that moment and the raw ingredients of a cycle count. When no call is being timed and the program counter equals a live table address, the profiler counts a hit for that slot, remembers the current cycle count and remembers the link value as the address the call will return to. When a later strobe arrives at that return address, the elapsed cycle count is folded into the slot's statistics: a running total, a minimum and a maximum.

Only one call is timed at a time; entry matches during a timed call are ignored. The table is searched one slot per clock, and the block raises `busy` while a search runs. Upstream logic must not present a new strobe while `busy` is high. A precomputed AND of all live table addresses acts as a cheap prefilter. If that value is nonzero and shares no set bit with the program counter, no table address can match, so the search is skipped.

The cycle count of a strobe is formed as base cycles plus instruction count plus bonus cycles plus memory operations multiplied by a programmable per-access cost, all modulo 2^32. Statistics are read, and the table and controls written, through a simple register port. The address of that port is a 3-bit region select above an entry index.

The control machine has three states:
- IDLE: no call is timed. A strobe that passes the prefilter takes the transition IDLE->SCAN. Any other strobe keeps the block in IDLE.
- SCAN: compares one slot per clock, starting at slot 1.
  - SCAN->MEASURE: the slot matches.
  - SCAN->IDLE: the slot is the last live slot and does not match.
  - SCAN->SCAN: otherwise, moving on to the next slot.
- MEASURE: a call is being timed.
  - MEASURE->SCAN: a strobe at the return address passes the prefilter. That same instruction is then searched as a possible new entry.
  - MEASURE->IDLE: a strobe at the return address that is filtered out.
  - MEASURE->MEASURE: any other strobe.

Top module: `call_profiler`

## Requirements
- R1: After reset `busy` is low, the end index and the access cost are 0, every hit count, total, minimum and maximum reads 0, and the hash reads 32'hFFFF_FFFF.
- R2: The cycle value of a strobe equals `cyc_base + cyc_insts + cyc_bonus + cyc_memops * cost` modulo 2^32, where cost is the 8-bit control field.
- R3: The hash, read at region 5 index 2, equals the bitwise AND of the table addresses in slots 1 to the end index. It is all ones when the end index is 0. It follows a table or end-index write within two clocks.
- R4: A strobe in IDLE whose PC ANDed with a nonzero hash gives zero starts no search, and `busy` stays low. With a zero hash every strobe is searched.
- R5: A search compares slot k in its k-th busy cycle. A match at slot k keeps `busy` high for exactly k cycles. A miss keeps it high for end-index cycles. Slots above the end index never match, and an end index of 0 starts no search.
- R6: A match increments that slot's hit count and starts a timed call, capturing the strobe's cycle value and its link value.
- R7: While a call is timed, strobes other than the return address change no state: no search starts and no hit count moves.
- R8: A strobe whose PC equals the captured link value ends the call with duration equal to its cycle value minus the captured one.
- R9: On the first completion of a slot (hit count 1), minimum and maximum are set to the duration and the total is set to the duration.
- R10: On later completions the minimum and maximum take the duration when it is smaller, respectively larger, and the duration is added to the total.
- R11: The total and the hit count saturate at 32'hFFFF_FFFF instead of wrapping.
- R12: Register map, as {region[2:0], index}. Region 0 is the table address of slot `index` (read/write). Regions 1, 2, 3 and 4 are hit count, total, minimum and maximum (read only). Region 5 is control: index 0 is the end index (writes above the slot count clamp to it), index 1 is the cost, index 2 is the hash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | One accepted instruction this cycle |
| instr_pc | input | 32 | Program counter of that instruction |
| link_addr | input | 32 | Link register value at that instruction |
| cyc_base | input | 32 | Base cycle count |
| cyc_insts | input | 32 | Instruction count |
| cyc_bonus | input | 32 | Bonus cycles |
| cyc_memops | input | 32 | Memory operation count |
| busy | output | 1 | Table search in progress; no strobe may be presented |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3+IDX_W | Register address {region, index} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |

## Verification
Every live slot is called in turn with several differing cycle spans, so that the busy duration pins down the slot's search position. The spans are ordered so that the first completion, a larger one and a smaller one each drive a different statistic. Strobes on other watched addresses during a timed call separate a single-call profiler from one that restarts or nests. PCs that miss the table, PCs removed by the prefilter and an address in a slot above the end index separate a full search from a skipped one. Very long spans repeated on one slot expose wrapping in place of saturation, and the varied memory-operation counts expose a wrong access-cost product.

// File: rtl/callprof_pkg.sv
package callprof_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SCAN    = 2'd1,
        ST_MEASURE = 2'd2
    } prof_state_e;

    localparam logic [2:0] RGN_WATCH = 3'd0;
    localparam logic [2:0] RGN_HITS  = 3'd1;
    localparam logic [2:0] RGN_TOTAL = 3'd2;
    localparam logic [2:0] RGN_MIN   = 3'd3;
    localparam logic [2:0] RGN_MAX   = 3'd4;
    localparam logic [2:0] RGN_CTRL  = 3'd5;

    localparam int CTL_END  = 0;
    localparam int CTL_COST = 1;
    localparam int CTL_HASH = 2;

endpackage

// File: rtl/callprof_cycle_sum.sv
module callprof_cycle_sum #(
    parameter int DW     = 32,
    parameter int COST_W = 8
) (
    input  logic [DW-1:0]     base_i,
    input  logic [DW-1:0]     insts_i,
    input  logic [DW-1:0]     bonus_i,
    input  logic [DW-1:0]     memops_i,
    input  logic [COST_W-1:0] cost_i,
    output logic [DW-1:0]     cycles_o
);
    logic [DW-1:0] mem_part;

    always_comb begin
        mem_part = memops_i * DW'(cost_i);
        cycles_o = base_i + insts_i + bonus_i + mem_part;
    end
endmodule

// File: rtl/callprof_and_hash.sv
module callprof_and_hash #(
    parameter int N_ENT = 80,
    parameter int DW    = 32,
    parameter int IDX_W = 7
) (
    input  logic [DW-1:0]    table_i [N_ENT],
    input  logic [IDX_W-1:0] live_i,
    output logic [DW-1:0]    hash_o
);
    always_comb begin
        hash_o = '1;
        for (int i = 0; i < N_ENT; i++) begin
            if (i < int'(live_i)) begin
                hash_o = hash_o & table_i[i];
            end
        end
    end
endmodule

// File: rtl/callprof_stat_calc.sv
module callprof_stat_calc #(
    parameter int DW = 32
) (
    input  logic          first_i,
    input  logic [DW-1:0] dur_i,
    input  logic [DW-1:0] tot_i,
    input  logic [DW-1:0] min_i,
    input  logic [DW-1:0] max_i,
    output logic [DW-1:0] tot_o,
    output logic [DW-1:0] min_o,
    output logic [DW-1:0] max_o
);
    logic [DW-1:0] tot_base;
    logic [DW:0]   tot_sum;

    always_comb begin
        tot_base = first_i ? '0 : tot_i;
        tot_sum  = {1'b0, tot_base} + {1'b0, dur_i};
        tot_o    = tot_sum[DW] ? '1 : tot_sum[DW-1:0];
        if (first_i) begin
            min_o = dur_i;
            max_o = dur_i;
        end else begin
            min_o = (dur_i < min_i) ? dur_i : min_i;
            max_o = (dur_i > max_i) ? dur_i : max_i;
        end
    end
endmodule

// File: rtl/call_profiler.sv
module call_profiler
    import callprof_pkg::*;
#(
    parameter int  N_ENT  = 80,
    parameter int  DW     = 32,
    parameter int  COST_W = 8,
    localparam int IDX_W  = $clog2(N_ENT + 1),
    localparam int AW     = 3 + IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [DW-1:0] instr_pc,
    input  logic [DW-1:0] link_addr,
    input  logic [DW-1:0] cyc_base,
    input  logic [DW-1:0] cyc_insts,
    input  logic [DW-1:0] cyc_bonus,
    input  logic [DW-1:0] cyc_memops,
    output logic          busy,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata
);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(N_ENT);
    localparam logic [IDX_W-1:0] ONE_IDX   = IDX_W'(1);

    // control state
    prof_state_e state_q, state_d;

    // per-slot storage (slot k held at array position k-1)
    logic [DW-1:0] watch_q [N_ENT];
    logic [DW-1:0] hits_q  [N_ENT];
    logic [DW-1:0] tot_q   [N_ENT];
    logic [DW-1:0] min_q   [N_ENT];
    logic [DW-1:0] max_q   [N_ENT];

    // configuration
    logic [IDX_W-1:0]  end_q;
    logic [COST_W-1:0] cost_q;
    logic [DW-1:0]     hash_q, hash_c;

    // search and measurement context
    logic [DW-1:0]    pc_q, link_q, cyc_q, start_q, endpc_q;
    logic [IDX_W-1:0] scan_q, act_q;
    logic [IDX_W-1:0] scan_slot, act_slot;
    logic [DW-1:0]    cyc_now, dur;
    logic [DW-1:0]    tot_n, min_n, max_n;
    logic             search_go, scan_hit, scan_last, ret_hit, accept, first_done;

    // register port decode
    logic [2:0]       rgn;
    logic [IDX_W-1:0] ridx, rslot;
    logic             ridx_ok;

    assign rgn     = cfg_addr[AW-1 -: 3];
    assign ridx    = cfg_addr[IDX_W-1:0];
    assign rslot   = ridx - ONE_IDX;
    assign ridx_ok = (ridx != '0) && (ridx <= LAST_SLOT);

    callprof_cycle_sum #(.DW(DW), .COST_W(COST_W)) u_cyc (
        .base_i   (cyc_base),
        .insts_i  (cyc_insts),
        .bonus_i  (cyc_bonus),
        .memops_i (cyc_memops),
        .cost_i   (cost_q),
        .cycles_o (cyc_now)
    );

    callprof_and_hash #(.N_ENT(N_ENT), .DW(DW), .IDX_W(IDX_W)) u_hash (
        .table_i (watch_q),
        .live_i  (end_q),
        .hash_o  (hash_c)
    );

    assign scan_slot  = scan_q - ONE_IDX;
    assign act_slot   = act_q - ONE_IDX;
    assign first_done = (hits_q[act_slot] == DW'(1));
    assign dur        = cyc_now - start_q;

    callprof_stat_calc #(.DW(DW)) u_stat (
        .first_i (first_done),
        .dur_i   (dur),
        .tot_i   (tot_q[act_slot]),
        .min_i   (min_q[act_slot]),
        .max_i   (max_q[act_slot]),
        .tot_o   (tot_n),
        .min_o   (min_n),
        .max_o   (max_n)
    );

    // decision terms
    assign search_go = (end_q != '0) &&
                       ((hash_q == '0) || ((instr_pc & hash_q) != '0));
    assign scan_hit  = (state_q == ST_SCAN) && (watch_q[scan_slot] == pc_q);
    assign scan_last = (scan_q >= end_q);
    assign ret_hit   = (state_q == ST_MEASURE) && instr_valid && (instr_pc == endpc_q);
    assign accept    = instr_valid && search_go && ((state_q == ST_IDLE) || ret_hit);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (scan_hit)       state_d = ST_MEASURE;
                else if (scan_last) state_d = ST_IDLE;
            end
            ST_MEASURE: begin
                if (ret_hit) state_d = accept ? ST_SCAN : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q == ST_SCAN);
        cfg_rdata = '0;
        unique case (rgn)
            RGN_WATCH: if (ridx_ok) cfg_rdata = watch_q[rslot];
            RGN_HITS:  if (ridx_ok) cfg_rdata = hits_q[rslot];
            RGN_TOTAL: if (ridx_ok) cfg_rdata = tot_q[rslot];
            RGN_MIN:   if (ridx_ok) cfg_rdata = min_q[rslot];
            RGN_MAX:   if (ridx_ok) cfg_rdata = max_q[rslot];
            RGN_CTRL: begin
                if (int'(ridx) == CTL_END)       cfg_rdata = DW'(end_q);
                else if (int'(ridx) == CTL_COST) cfg_rdata = DW'(cost_q);
                else if (int'(ridx) == CTL_HASH) cfg_rdata = hash_q;
            end
            default: cfg_rdata = '0;
        endcase
    end

    // configuration registers and precomputed hash
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_q  <= '0;
            cost_q <= '0;
            hash_q <= '1;
            for (int i = 0; i < N_ENT; i++) watch_q[i] <= '0;
        end else begin
            hash_q <= hash_c;
            if (cfg_we) begin
                if (rgn == RGN_WATCH && ridx_ok) begin
                    watch_q[rslot] <= cfg_wdata;
                end
                if (rgn == RGN_CTRL && int'(ridx) == CTL_END) begin
                    end_q <= (cfg_wdata > DW'(N_ENT)) ? LAST_SLOT : cfg_wdata[IDX_W-1:0];
                end
                if (rgn == RGN_CTRL && int'(ridx) == CTL_COST) begin
                    cost_q <= cfg_wdata[COST_W-1:0];
                end
            end
        end
    end

    // search and measurement context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            link_q  <= '0;
            cyc_q   <= '0;
            start_q <= '0;
            endpc_q <= '0;
            scan_q  <= ONE_IDX;
            act_q   <= ONE_IDX;
        end else begin
            if (accept) begin
                pc_q   <= instr_pc;
                link_q <= link_addr;
                cyc_q  <= cyc_now;
                scan_q <= ONE_IDX;
            end else if (state_q == ST_SCAN && !scan_hit && !scan_last) begin
                scan_q <= scan_q + ONE_IDX;
            end
            if (scan_hit) begin
                start_q <= cyc_q;
                endpc_q <= link_q;
                act_q   <= scan_q;
            end else if (ret_hit) begin
                endpc_q <= '0;
            end
        end
    end

    // statistics
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) begin
                hits_q[i] <= '0;
                tot_q[i]  <= '0;
                min_q[i]  <= '0;
                max_q[i]  <= '0;
            end
        end else begin
            if (scan_hit && hits_q[scan_slot] != '1) begin
                hits_q[scan_slot] <= hits_q[scan_slot] + DW'(1);
            end
            if (ret_hit) begin
                tot_q[act_slot] <= tot_n;
                min_q[act_slot] <= min_n;
                max_q[act_slot] <= max_n;
            end
        end
    end
endmodule

// File: rtl/callprof_checker.sv
module callprof_checker
    import callprof_pkg::*;
#(
    parameter int N_ENT = 80,
    parameter int DW    = 32,
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             instr_valid,
    input logic [DW-1:0]    instr_pc,
    input logic [DW-1:0]    hash,
    input logic [DW-1:0]    endpc,
    input prof_state_e      state,
    input logic [IDX_W-1:0] scan_idx,
    input logic [DW-1:0]    act_min,
    input logic [DW-1:0]    act_max,
    input logic [DW-1:0]    act_tot
);
    assert_scan_in_table_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (scan_idx != '0 && int'(scan_idx) <= N_ENT));

    assert_prefilter_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && instr_valid && hash != '0 && (instr_pc & hash) == '0)
        |=> !busy);

    assert_single_call_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEASURE && !(instr_valid && instr_pc == endpc))
        |=> (state == ST_MEASURE && !busy));

    assert_min_not_above_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEASURE) |-> (act_min <= act_max));

    assert_total_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEASURE) |=> (act_tot >= $past(act_tot)));
endmodule

bind call_profiler callprof_checker #(.N_ENT(N_ENT), .DW(DW), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .instr_valid (instr_valid),
    .instr_pc    (instr_pc),
    .hash        (hash_q),
    .endpc       (endpc_q),
    .state       (state_q),
    .scan_idx    (scan_q),
    .act_min     (min_q[act_slot]),
    .act_max     (max_q[act_slot]),
    .act_tot     (tot_q[act_slot])
);

// File: tb/call_profiler_tb_top.sv
module call_profiler_tb_top;
    localparam int N  = 4;
    localparam int IW = $clog2(N + 1);
    localparam int AW = 3 + IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [31:0]   instr_pc = '0, link_addr = '0;
    logic [31:0]   cyc_base = '0, cyc_insts = '0, cyc_bonus = '0, cyc_memops = '0;
    logic          busy;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] wtab  [1:N];
    logic [31:0] m_hit [1:N];
    logic [31:0] m_tot [1:N];
    logic [31:0] m_min [1:N];
    logic [31:0] m_max [1:N];
    logic [31:0] cost = 32'd3;

    always #2 clk = ~clk;

    call_profiler #(.N_ENT(N), .DW(32), .COST_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_pc(instr_pc),
        .link_addr(link_addr), .cyc_base(cyc_base), .cyc_insts(cyc_insts),
        .cyc_bonus(cyc_bonus), .cyc_memops(cyc_memops), .busy(busy),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ra(input int rgn, input int idx);
        return {3'(rgn), IW'(idx)};
    endfunction

    function automatic logic [31:0] cyc(input logic [31:0] b, input logic [31:0] i,
                                        input logic [31:0] bo, input logic [31:0] m);
        return b + i + bo + m * cost;
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic strobe(input logic [31:0] pc, input logic [31:0] lnk,
                          input logic [31:0] b, input logic [31:0] i,
                          input logic [31:0] bo, input logic [31:0] m, output int nbusy);
        @(negedge clk);
        instr_pc = pc; link_addr = lnk;
        cyc_base = b; cyc_insts = i; cyc_bonus = bo; cyc_memops = m;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        nbusy = 0;
        while (busy) begin
            nbusy++;
            @(negedge clk);
        end
    endtask

    task automatic stat_check(input int j, input string tag);
        logic [31:0] v;
        rd(ra(1, j), v); check({tag, " hits R6"}, v, m_hit[j]);
        rd(ra(2, j), v); check({tag, " total R9 R10 R11"}, v, m_tot[j]);
        rd(ra(3, j), v); check({tag, " min R9 R10"}, v, m_min[j]);
        rd(ra(4, j), v); check({tag, " max R9 R10"}, v, m_max[j]);
    endtask

    // one timed call of slot j; the call ends at return address lnk
    task automatic do_call(input int j, input logic [31:0] b0, input logic [31:0] b1,
                           input int s);
        int nb;
        logic [31:0] c0, c1, d, sum;
        int other;
        logic [31:0] lnk;
        lnk = 32'h0000_8000 + 32'(j * 16);
        c0 = cyc(b0, 32'(s), 32'(s % 3), 32'(s % 5));
        strobe(wtab[j], lnk, b0, 32'(s), 32'(s % 3), 32'(s % 5), nb);
        check($sformatf("R5 busy cycles slot %0d", j), 32'(nb), 32'(j));
        if (m_hit[j] != '1) m_hit[j] = m_hit[j] + 1;
        // another watched address while timed: ignored
        other = (j % 3) + 1;
        strobe(wtab[other], 32'h0000_9000, 32'd5, 32'd0, 32'd0, 32'd0, nb);
        check("R7 no search while timed", 32'(nb), 32'd0);
        c1 = cyc(b1, 32'(s + 11), 32'((s * 7) % 4), 32'(s % 5 + 2));
        strobe(lnk, 32'h0, b1, 32'(s + 11), 32'((s * 7) % 4), 32'(s % 5 + 2), nb);
        check("R8 return not searched", 32'(nb), 32'd0);
        d = c1 - c0;
        if (m_hit[j] == 32'd1) begin
            m_tot[j] = d; m_min[j] = d; m_max[j] = d;
        end else begin
            sum = m_tot[j] + d;
            m_tot[j] = (sum < m_tot[j]) ? 32'hFFFF_FFFF : sum;
            if (d < m_min[j]) m_min[j] = d;
            if (d > m_max[j]) m_max[j] = d;
        end
        stat_check(j, $sformatf("R2 R8 slot %0d call %0d", j, s));
        stat_check(other, "R7 untouched slot");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int nb;
        wtab[1] = 32'h0000_1100; wtab[2] = 32'h0000_1240;
        wtab[3] = 32'h0000_1380; wtab[4] = 32'h0000_2400;
        for (int k = 1; k <= N; k++) begin
            m_hit[k] = '0; m_tot[k] = '0; m_min[k] = '0; m_max[k] = '0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 busy after reset", 32'(busy), 32'd0);
        rd(ra(5, 0), v); check("R1 end index", v, 32'd0);
        rd(ra(5, 1), v); check("R1 cost", v, 32'd0);
        rd(ra(5, 2), v); check("R1 R3 empty hash", v, 32'hFFFF_FFFF);
        for (int k = 1; k <= N; k++) stat_check(k, "R1 reset stats");

        // empty table: no search
        strobe(32'h0000_1100, 32'h0, 0, 0, 0, 0, nb);
        check("R5 empty table no search", 32'(nb), 32'd0);

        // R12 register map
        for (int k = 1; k <= N; k++) wr(ra(0, k), wtab[k]);
        wr(ra(5, 1), cost);
        wr(ra(5, 0), 32'd200);
        rd(ra(5, 0), v); check("R12 end index clamp", v, 32'(N));
        rd(ra(0, 2), v); check("R12 table readback", v, wtab[2]);
        rd(ra(5, 1), v); check("R12 cost readback", v, cost);
        rd(ra(5, 2), v); check("R3 hash four slots", v, 32'h0);

        // zero hash: everything searched, full miss scans all slots
        strobe(32'h0000_0010, 32'h0, 0, 0, 0, 0, nb);
        check("R4 R5 zero hash full miss", 32'(nb), 32'(N));

        wr(ra(5, 0), 32'd3);
        rd(ra(5, 2), v); check("R3 hash three slots", v, 32'h0000_1000);

        strobe(32'h0000_0FF0, 32'h0, 0, 0, 0, 0, nb);
        check("R4 prefilter skip", 32'(nb), 32'd0);
        strobe(32'h0000_1FF0, 32'h0, 0, 0, 0, 0, nb);
        check("R5 miss scans end index", 32'(nb), 32'd3);
        strobe(wtab[4], 32'h0, 0, 0, 0, 0, nb);
        check("R4 R5 slot above end skipped", 32'(nb), 32'd0);

        // sweep: every live slot, spans chosen first / larger / smaller
        for (int j = 1; j <= 3; j++) begin
            do_call(j, 32'(1000 * j), 32'(1000 * j + 400 + 37 * j), 1);
            do_call(j, 32'(5000 + 13 * j), 32'(5000 + 13 * j + 900), 2);
            do_call(j, 32'(9000), 32'(9000 + 20 + j), 3);
        end

        // R11 saturation of the total
        do_call(1, 32'h0000_0100, 32'hF000_0100, 4);
        do_call(1, 32'h0000_0100, 32'hF000_0100, 4);
        rd(ra(2, 1), v); check("R11 total saturates", v, 32'hFFFF_FFFF);

        rd(ra(1, 4), v); check("R5 slot above end never hit", v, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule